// File: doc/BRIEF.md
# Multi-lane SPI frame shifter

This block moves one serial frame between a parallel word and up to four SPI data lanes. When a frame starts it captures a transmit word and the frame format. It then presents the outgoing bits on the lanes, one, two or four bits per serial clock period. It also gathers the incoming bits into a right-aligned receive word, which it hands to the receive queue with a one-cycle push strobe. A separate clock sequencer supplies the serial clock timing as single-cycle leading-edge and trailing-edge strobes, together with the phase setting. The shifter itself never generates the serial clock.

Four settings are sampled when a frame starts: the lane width, the bit order, the frame length and a transmit-only direction. A transmit-only frame drives every active lane and produces no receive push. A frame in either multi-lane mode without that setting leaves the lanes undriven and samples them. In single-lane mode the block always drives lane 0 and always samples lane 1.

Top module: `spi_lane_shifter`

## Requirements
- R1: After reset the block is idle, with `busy`, `rxPush`, `dqOe` and `dqOut` all zero.
- R2: The `fmtProto` code selects the lane width: 0 selects one lane, 1 selects two, 2 selects four, and code 3 behaves as one lane. In one-lane mode the data leaves on lane 0 and enters on lane 1.
- R3: Within each shift step the earliest bit of the frame is on the highest active lane. Lane k of step j carries frame bit j*n + (n-1-k), where n is the lane count. With `fmtLsbFirst` low the frame bits are the word's low L bits, sent from the most significant one down.
- R4: When `fmtLsbFirst` is 1, frame bit t is word bit t on transmit, and the t-th received bit lands in `rxWord[t]`.
- R5: `fmtLen` gives the frame length L, from 1 to 8; a value of 0 or above 8 means 8. Only the low L bits of `txWord` are sent. The frame ends after ceil(L/n) sample strobes, and the lanes that are left over in the last partial step drive 0.
- R6: In most-significant-first order the t-th received bit lands in `rxWord[L-1-t]`, and the bits above L are 0. `rxPush` is high for exactly one cycle, the cycle after the final sample strobe, and `busy` is low in that same cycle.
- R7: While busy, `dqOe` is 4'b0001 in one-lane mode. In multi-lane mode it is the low n lanes when `fmtTxOnly` is 1 and 0 when it is 0. A transmit-only frame never raises `rxPush`.
- R8: With `cpha` 0, the first step is on the lanes in the cycle after the start. Sampling happens on the leading strobe, and the lanes advance to the next step on the trailing strobe.
- R9: With `cpha` 1, `dqOut` stays 0 until the first leading strobe. Each leading strobe launches a step, and sampling happens on the trailing strobe.
- R10: A `frameStart` that arrives while busy is ignored, even in the same cycle as the final sample strobe. Format inputs that change during a frame have no effect on it.
- R11: While idle, `dqOut` and `dqOe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fmtProto | input | 2 | Lane width code |
| fmtLsbFirst | input | 1 | Least significant bit first when 1 |
| fmtTxOnly | input | 1 | Transmit-only frame when 1 |
| fmtLen | input | 4 | Frame length in bits |
| cpha | input | 1 | Clock phase from the sequencer |
| txWord | input | 8 | Word from the transmit queue |
| frameStart | input | 1 | Starts a frame when idle |
| sckLead | input | 1 | Leading serial clock edge strobe |
| sckTrail | input | 1 | Trailing serial clock edge strobe |
| dqIn | input | 4 | Sampled lane levels |
| dqOut | output | 4 | Driven lane levels |
| dqOe | output | 4 | Per-lane output enable |
| rxWord | output | 8 | Received word, right-aligned |
| rxPush | output | 1 | Push strobe to the receive queue |
| busy | output | 1 | Frame in progress |

## Verification
A new `frameStart` can coincide with the final sample strobe of the current frame, which is the cycle in which the frame completes. The bench raises `frameStart` inside that strobe on chosen frames, and also inside an earlier sample strobe. It judges the result by seeing `busy` and `dqOe` fall right after the receive push, with no second frame loaded. It also scrambles the format inputs just after each start, so any use of a live setting instead of the captured one shows up in the lane values or in the received word.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int FRAME_W = 8;
  localparam int LEN_W   = 4;
  localparam int LANE_N  = 4;
  localparam int ACC_W   = FRAME_W + LANE_N;

  typedef struct packed {
    logic [1:0]       laneLog;
    logic [LEN_W-1:0] bitLen;
    logic             lsbFirst;
    logic             txOnly;
    logic [LEN_W-1:0] shifts;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
    logic busy;
    logic launched;
  } stb_t;

  function automatic logic [LEN_W-1:0] normLen(input logic [LEN_W-1:0] raw);
    if (raw == '0 || int'(raw) > FRAME_W) return LEN_W'(FRAME_W);
    return raw;
  endfunction
endpackage

// File: rtl/spi_lane_ctl.sv
module spi_lane_ctl
  import spi_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       fmtProto,
  input  logic             fmtLsbFirst,
  input  logic             fmtTxOnly,
  input  logic [LEN_W-1:0] fmtLen,
  input  logic             cpha,
  input  logic             frameStart,
  input  logic             sckLead,
  input  logic             sckTrail,
  output cfg_t             cfg,
  output stb_t             stb
);
  timeunit 1ns;
  timeprecision 100ps;

  cfg_t             cfgLive;
  logic             busy;
  logic             launched;
  logic             phaseLate;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   roundUp;

  always_comb begin
    cfgLive.laneLog  = (fmtProto == 2'd1) ? 2'd1 : (fmtProto == 2'd2) ? 2'd2 : 2'd0;
    cfgLive.bitLen   = normLen(fmtLen);
    cfgLive.lsbFirst = fmtLsbFirst;
    cfgLive.txOnly   = fmtTxOnly;
    roundUp = {1'b0, cfgLive.bitLen} + (((LEN_W+1)'(1)) << cfgLive.laneLog) - (LEN_W+1)'(1);
    cfgLive.shifts   = LEN_W'(roundUp >> cfgLive.laneLog);
  end

  always_comb begin
    stb.load     = frameStart && !busy;
    stb.shift    = busy && (phaseLate ? (sckLead && launched) : sckTrail);
    stb.sample   = busy && (phaseLate ? (sckTrail && launched) : sckLead);
    stb.finish   = stb.sample && (cnt == cfg.shifts - LEN_W'(1));
    stb.busy     = busy;
    stb.launched = launched;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      launched  <= 1'b0;
      phaseLate <= 1'b0;
      cnt       <= '0;
      cfg       <= '0;
    end else if (stb.load) begin
      busy      <= 1'b1;
      cfg       <= cfgLive;
      phaseLate <= cpha;
      launched  <= !cpha;
      cnt       <= '0;
    end else if (busy) begin
      if (phaseLate && sckLead) launched <= 1'b1;
      if (stb.sample) cnt <= cnt + LEN_W'(1);
      if (stb.finish) begin
        busy     <= 1'b0;
        launched <= 1'b0;
      end
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < cfg.shifts));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && frameStart && !stb.finish) |=> (busy && $stable(cfg)));
endmodule

// File: rtl/spi_lane_dp.sv
module spi_lane_dp
  import spi_lane_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfg_t               cfg,
  input  stb_t               stb,
  input  logic [LEN_W-1:0]   fmtLen,
  input  logic               fmtLsbFirst,
  input  logic [FRAME_W-1:0] txWord,
  input  logic [LANE_N-1:0]  dqIn,
  output logic [LANE_N-1:0]  dqOut,
  output logic [LANE_N-1:0]  dqOe,
  output logic [FRAME_W-1:0] rxWord,
  output logic               rxPush
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IDX_W  = $clog2(FRAME_W);
  localparam int AIDX_W = $clog2(ACC_W);

  logic [FRAME_W-1:0] sr;
  logic [FRAME_W-1:0] txAligned;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   accNext;
  logic [ACC_W-1:0]   raw;
  logic [FRAME_W-1:0] rxNext;
  logic [LEN_W-1:0]   loadLen;
  logic [LEN_W+1:0]   span;
  logic [LEN_W+1:0]   drop;
  logic [2:0]         nLanes;

  assign nLanes = 3'(1) << cfg.laneLog;

  // Transmit word is reordered at load so the first frame bit sits on top.
  always_comb begin
    loadLen   = normLen(fmtLen);
    txAligned = '0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (i < int'(loadLen)) begin
        if (fmtLsbFirst) txAligned[FRAME_W-1-i] = txWord[IDX_W'(i)];
        else txAligned[FRAME_W-1-i] = txWord[IDX_W'(int'(loadLen) - 1 - i)];
      end
    end
  end

  always_comb begin
    dqOut = '0;
    for (int k = 0; k < LANE_N; k++) begin
      if (stb.busy && stb.launched && k < int'(nLanes))
        dqOut[k] = sr[IDX_W'(FRAME_W - int'(nLanes) + k)];
    end
  end

  always_comb begin
    dqOe = '0;
    if (stb.busy) begin
      if (cfg.laneLog == 2'd0) dqOe = 4'b0001;
      else if (cfg.txOnly) dqOe = LANE_N'((5'd1 << nLanes) - 5'd1);
    end
  end

  always_comb begin
    case (cfg.laneLog)
      2'd1:    accNext = {acc[ACC_W-3:0], dqIn[1:0]};
      2'd2:    accNext = {acc[ACC_W-LANE_N-1:0], dqIn};
      default: accNext = {acc[ACC_W-2:0], dqIn[1]};
    endcase
    span = {2'b00, cfg.shifts} << cfg.laneLog;
    drop = span - {2'b00, cfg.bitLen};
    raw  = accNext >> drop;
    rxNext = '0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (i < int'(cfg.bitLen)) begin
        if (cfg.lsbFirst) rxNext[i] = raw[AIDX_W'(int'(cfg.bitLen) - 1 - i)];
        else rxNext[i] = raw[AIDX_W'(i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr     <= '0;
      acc    <= '0;
      rxWord <= '0;
      rxPush <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      if (stb.load) begin
        sr  <= txAligned;
        acc <= '0;
      end else begin
        if (stb.shift) sr <= sr << nLanes;
        if (stb.sample) acc <= accNext;
        if (stb.finish && !cfg.txOnly) begin
          rxWord <= rxNext;
          rxPush <= 1'b1;
        end
      end
    end
  end

  // R6
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush);

  // R7
  txonly_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> (!cfg.txOnly && !stb.busy));
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_lane_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         fmtProto,
  input  logic               fmtLsbFirst,
  input  logic               fmtTxOnly,
  input  logic [LEN_W-1:0]   fmtLen,
  input  logic               cpha,
  input  logic [FRAME_W-1:0] txWord,
  input  logic               frameStart,
  input  logic               sckLead,
  input  logic               sckTrail,
  input  logic [LANE_N-1:0]  dqIn,
  output logic [LANE_N-1:0]  dqOut,
  output logic [LANE_N-1:0]  dqOe,
  output logic [FRAME_W-1:0] rxWord,
  output logic               rxPush,
  output logic               busy
);
  timeunit 1ns;
  timeprecision 100ps;

  cfg_t cfg;
  stb_t stb;

  spi_lane_ctl uCtl (
    .clk(clk), .rstN(rstN), .fmtProto(fmtProto), .fmtLsbFirst(fmtLsbFirst),
    .fmtTxOnly(fmtTxOnly), .fmtLen(fmtLen), .cpha(cpha), .frameStart(frameStart),
    .sckLead(sckLead), .sckTrail(sckTrail), .cfg(cfg), .stb(stb)
  );

  spi_lane_dp uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .fmtLen(fmtLen),
    .fmtLsbFirst(fmtLsbFirst), .txWord(txWord), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .rxWord(rxWord), .rxPush(rxPush)
  );

  assign busy = stb.busy;

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (dqOe == '0 && dqOut == '0));
endmodule

// File: tb/sim_spi_lane_shifter.sv
module sim_spi_lane_shifter;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] fmtProto = '0;
  logic       fmtLsbFirst = 1'b0;
  logic       fmtTxOnly = 1'b0;
  logic [3:0] fmtLen = 4'd8;
  logic       cpha = 1'b0;
  logic [7:0] txWord = '0;
  logic       frameStart = 1'b0;
  logic       sckLead = 1'b0;
  logic       sckTrail = 1'b0;
  logic [3:0] dqIn = '0;
  logic [3:0] dqOut;
  logic [3:0] dqOe;
  logic [7:0] rxWord;
  logic       rxPush;
  logic       busy;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spi_lane_shifter u0 (
    .clk(clk), .rstN(rstN), .fmtProto(fmtProto), .fmtLsbFirst(fmtLsbFirst),
    .fmtTxOnly(fmtTxOnly), .fmtLen(fmtLen), .cpha(cpha), .txWord(txWord),
    .frameStart(frameStart), .sckLead(sckLead), .sckTrail(sckTrail), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .rxWord(rxWord), .rxPush(rxPush), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int laneCount(input int proto);
    return (proto == 1) ? 2 : (proto == 2) ? 4 : 1;
  endfunction

  function automatic int effLen(input int len);
    return (len == 0 || len > 8) ? 8 : len;
  endfunction

  function automatic logic [3:0] expTx(input logic [7:0] w, input int len, input bit lsb,
                                       input int n, input int j);
    logic [3:0] r = '0;
    for (int k = 0; k < n; k++) begin
      int t = j * n + (n - 1 - k);
      if (t < len) r[k] = lsb ? w[t] : w[len - 1 - t];
    end
    return r;
  endfunction

  function automatic logic [3:0] expOe(input int n, input bit txo);
    if (n == 1) return 4'b0001;
    return txo ? 4'((1 << n) - 1) : 4'b0000;
  endfunction

  function automatic string txTag(input int proto, input int len, input bit lsb);
    if (proto == 3) return "R2";
    if (len != 8) return "R5";
    return lsb ? "R4" : "R3";
  endfunction

  task automatic pulse(input bit lead, input bit alsoStart);
    @(negedge clk);
    sckLead = lead;
    sckTrail = !lead;
    frameStart = alsoStart;
    @(negedge clk);
    sckLead = 1'b0;
    sckTrail = 1'b0;
    frameStart = 1'b0;
  endtask

  // intr: 0 none, 1 start during an early sample, 2 start with the final sample
  task automatic runFrame(input int proto, input bit lsb, input bit txo, input int lenRaw,
                          input bit cp, input logic [7:0] w, input int intr);
    int n = laneCount(proto);
    int len = effLen(lenRaw);
    int steps = (len + n - 1) / n;
    logic [15:0] rstream = '0;
    logic [7:0] rxExp = '0;
    string tg = txTag(proto, lenRaw, lsb);
    @(negedge clk);
    fmtProto = 2'(proto);
    fmtLsbFirst = lsb;
    fmtTxOnly = txo;
    fmtLen = 4'(lenRaw);
    cpha = cp;
    txWord = w;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    // R10: scramble live settings; the frame must use the captured ones
    fmtProto = 2'($urandom);
    fmtLsbFirst = 1'($urandom);
    fmtTxOnly = 1'($urandom);
    fmtLen = 4'($urandom);
    cpha = 1'($urandom);
    txWord = 8'($urandom);
    chk("R8 busy after start", int'(busy), 1);
    chk("R7 output enable", int'(dqOe), int'(expOe(n, txo)));
    if (!cp) chk("R8 first step before edge", int'(dqOut), int'(expTx(w, len, lsb, n, 0)));
    else chk("R9 lanes quiet before lead", int'(dqOut), 0);
    for (int j = 0; j < steps; j++) begin
      logic [3:0] rxc;
      bit st;
      if (cp) begin
        pulse(1'b1, 1'b0);
        chk(tg, int'(dqOut), int'(expTx(w, len, lsb, n, j)));
      end
      rxc = 4'($urandom);
      dqIn = rxc;
      for (int k = 0; k < n; k++) begin
        int t = j * n + (n - 1 - k);
        if (t < len) rstream[t] = (n == 1) ? rxc[1] : rxc[k];
      end
      st = (intr == 1 && j == 0 && steps > 1) || (intr == 2 && j == steps - 1);
      pulse(!cp, st);
      if (j == steps - 1) begin
        for (int t = 0; t < len; t++) begin
          if (lsb) rxExp[t] = rstream[t];
          else rxExp[len - 1 - t] = rstream[t];
        end
        chk("R5 frame ends", int'(busy), 0);
        chk("R7 push only when receiving", int'(rxPush), int'(!txo));
        if (!txo) chk(lsb ? "R4 rx word" : "R6 rx word", int'(rxWord), int'(rxExp));
        @(negedge clk);
        chk("R6 push one cycle", int'(rxPush), 0);
        chk("R10 no second frame", int'(busy), 0);
        chk("R11 idle enables", int'(dqOe), 0);
        chk("R11 idle lanes", int'(dqOut), 0);
      end else if (!cp) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk("R8 hold until trail", int'(dqOut), int'(expTx(w, len, lsb, n, j)));
        pulse(1'b0, 1'b0);
        chk(tg, int'(dqOut), int'(expTx(w, len, lsb, n, j + 1)));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 push", int'(rxPush), 0);
    chk("R1 enables", int'(dqOe), 0);
    chk("R1 lanes", int'(dqOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed: each lane code, both orders, both phases
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 2; o++)
        for (int c = 0; c < 2; c++) begin
          runFrame(p, 1'(o), 1'b0, 8, 1'(c), 8'hA6, 0);
          runFrame(p, 1'(o), 1'b1, 8, 1'(c), 8'h3C, 0);
        end
    // directed lengths, including out-of-range codes
    runFrame(2, 1'b0, 1'b0, 1, 1'b0, 8'hFF, 0);
    runFrame(2, 1'b1, 1'b0, 3, 1'b1, 8'h05, 0);
    runFrame(1, 1'b0, 1'b1, 5, 1'b0, 8'h1B, 0);
    runFrame(1, 1'b1, 1'b0, 7, 1'b1, 8'hC3, 0);
    runFrame(2, 1'b0, 1'b0, 0, 1'b0, 8'h96, 0);
    runFrame(0, 1'b1, 1'b0, 15, 1'b1, 8'h71, 0);
    runFrame(2, 1'b0, 1'b1, 6, 1'b1, 8'hE7, 0);
    // starts that collide with an active frame
    runFrame(0, 1'b0, 1'b0, 8, 1'b0, 8'h5A, 1);
    runFrame(2, 1'b1, 1'b0, 5, 1'b1, 8'hB4, 2);
    runFrame(1, 1'b0, 1'b0, 8, 1'b0, 8'h69, 2);
    for (int i = 0; i < 200; i++)
      runFrame($urandom_range(0, 3), 1'($urandom), 1'($urandom), $urandom_range(0, 15),
               1'($urandom), 8'($urandom), $urandom_range(0, 2));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule